// File: doc/BRIEF.md
# Alarm Status and Interrupt Register Bank

This block collects five alarm indications from a line receiver and presents them to a host through a small synchronous register port. Three of them are level conditions: loss of signal, alarm indication signal, and driver open. The block shows their current values in a live status register. Each change of one of these levels, rising or falling, is latched as an event. The other two are elastic-store overflow and underflow pulses. They are latched as sticky events that stay set until the host reads them.

All five events sit in one event register, which clears when the host reads it. A mask register uses write-one semantics. Writing 1 to a source's bit discards that source's pending event and masks the source. A single registered interrupt line is raised while any unmasked event is pending.

The host port has an address, write data, write enable and read enable. Read data is registered and appears in the cycle after the read strobe. Register map:

| Address | Register | Bits |
|---|---|---|
| 0 | live status | bit 0 loss of signal, bit 1 alarm indication, bit 2 driver open |
| 1 | events | bits 0..2 as status, bit 3 store overflow, bit 4 store underflow |
| 2 | mask | bits 0..4 as events |
| 3 | reserved | none |

Top module: `alarmRegBank`

## Requirements
- R1: A read of address 0 returns the three live alarm inputs in bits 0 (loss of signal), 1 (alarm indication) and 2 (driver open), as sampled at the clock edge before the read edge. The upper bits are 0. Read data appears on the cycle after the read strobe.
- R2: When a live alarm input differs from its value at the previous clock edge, in either direction, bit 0, 1 or 2 of the event register (address 1) becomes 1 at that edge.
- R3: A 1 on the overflow input sets event bit 3, and a 1 on the underflow input sets event bit 4. The bit stays 1 after the pulse ends, until the event register is read.
- R4: A read of address 1 returns the event bits that were pending before the read edge, and it clears all of them. An event that arrives at the same edge as the read stays pending.
- R5: A write of address 2 with bit i set clears pending event bit i and sets mask bit i. An event on the same source at the same edge stays pending.
- R6: Writing 0 to a mask bit leaves it unchanged. The mask register reads back at address 2 in bits 0..4.
- R7: irqOut is 1 exactly one cycle after a cycle in which some event bit is pending with its mask bit clear, and is 0 otherwise.
- R8: While rstN is low and after reset, every status, event and mask bit is 0, and irqOut and the read data are 0.
- R9: A read of address 3 returns 0. Writes to addresses 0, 1 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| losIn | input | 1 | live loss-of-signal condition |
| aisIn | input | 1 | live alarm-indication condition |
| drvOpenIn | input | 1 | live driver-open condition |
| esOvfIn | input | 1 | elastic-store overflow pulse |
| esUnfIn | input | 1 | elastic-store underflow pulse |
| regAddr | input | 2 | register address |
| regWrData | input | 8 | write data |
| regWe | input | 1 | write enable |
| regRe | input | 1 | read enable |
| regRdData | output | 8 | registered read data |
| irqOut | output | 1 | registered interrupt request |

## Verification
The assertions check four things on every cycle. The status register follows the live inputs one edge late. Every status change leaves its event bit set, and sticky pulses latch. Pending bits fall only on an event read or a mask write, and mask bits never fall. The interrupt follows unmasked pending bits by exactly one cycle. The bench's scenarios show the values returned by reads, including the cases where an event meets a read or a mask write at the same edge. They also show that writing 0 or writing to other addresses has no effect, and that a reserved read returns zero.

// File: rtl/alarmRegPkg.sv
package alarmRegPkg;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_EVENT  = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_RSVD   = 2'd3
  } regAddr_e;

  // strobes from the host decoder to the datapath
  typedef struct packed {
    logic rdAny;
    logic rdStatus;
    logic rdEvent;
    logic rdMask;
    logic wrMask;
  } alarmCtrl_t;

endpackage

// File: rtl/alarmRegCtrl.sv
module alarmRegCtrl
  import alarmRegPkg::*;
(
  input  logic [1:0] regAddr,
  input  logic       regWe,
  input  logic       regRe,
  output alarmCtrl_t ctrl
);

  regAddr_e addrSel;

  always_comb begin
    addrSel       = regAddr_e'(regAddr);
    ctrl          = '0;
    ctrl.rdAny    = regRe;
    ctrl.rdStatus = regRe && (addrSel == ADDR_STATUS);
    ctrl.rdEvent  = regRe && (addrSel == ADDR_EVENT);   // R4 clear-on-read
    ctrl.rdMask   = regRe && (addrSel == ADDR_MASK);
    // only the mask register is writable (R9)
    ctrl.wrMask   = regWe && (addrSel == ADDR_MASK);
  end

endmodule

// File: rtl/alarmRegDatapath.sv
module alarmRegDatapath
  import alarmRegPkg::*;
#(
  parameter int NUM_LIVE   = 3,
  parameter int NUM_STICKY = 2,
  parameter int DATA_W     = 8,
  localparam int NUM_SRC   = NUM_LIVE + NUM_STICKY
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LIVE-1:0] liveIn,
  input  logic [NUM_STICKY-1:0] stickyIn,
  input  logic [NUM_SRC-1:0]  wrBits,
  input  alarmCtrl_t          ctrl,
  output logic [NUM_LIVE-1:0] statusQ,
  output logic [NUM_SRC-1:0]  pendingQ,
  output logic [NUM_SRC-1:0]  maskQ,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);

  logic [NUM_LIVE-1:0] liveEvt;
  logic [NUM_SRC-1:0]  srcEvt;
  logic [NUM_SRC-1:0]  clrVec;
  logic [NUM_SRC-1:0]  pendingNext;
  logic [NUM_SRC-1:0]  maskNext;
  logic [DATA_W-1:0]   rdNext;
  logic                irqNext;

  // R2: edge detect against the registered status copy
  genvar gi;
  generate
    for (gi = 0; gi < NUM_LIVE; gi++) begin : gLiveEdge
      assign liveEvt[gi] = liveIn[gi] ^ statusQ[gi];
    end
  endgenerate

  assign srcEvt = {stickyIn, liveEvt};

  always_comb begin
    clrVec = '0;
    if (ctrl.rdEvent) clrVec = '1;
    if (ctrl.wrMask)  clrVec = clrVec | wrBits;
    // clear first, then new events: an arriving event wins (R4, R5)
    pendingNext = (pendingQ & ~clrVec) | srcEvt;
    maskNext    = ctrl.wrMask ? (maskQ | wrBits) : maskQ;  // R6
    irqNext     = |(pendingQ & ~maskQ);                    // R7
  end

  always_comb begin
    rdNext = '0;
    if (ctrl.rdStatus)     rdNext[NUM_LIVE-1:0] = statusQ;
    else if (ctrl.rdEvent) rdNext[NUM_SRC-1:0]  = pendingQ;
    else if (ctrl.rdMask)  rdNext[NUM_SRC-1:0]  = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      pendingQ <= '0;
      maskQ    <= '0;
      rdData   <= '0;
      irqOut   <= 1'b0;
    end else begin
      statusQ  <= liveIn;
      pendingQ <= pendingNext;
      maskQ    <= maskNext;
      irqOut   <= irqNext;
      if (ctrl.rdAny) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/alarmRegBank.sv
module alarmRegBank
  import alarmRegPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              losIn,
  input  logic              aisIn,
  input  logic              drvOpenIn,
  input  logic              esOvfIn,
  input  logic              esUnfIn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWe,
  input  logic              regRe,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int NUM_LIVE   = 3;
  localparam int NUM_STICKY = 2;
  localparam int NUM_SRC    = NUM_LIVE + NUM_STICKY;

  alarmCtrl_t          ctrlS;
  logic [NUM_LIVE-1:0] statusQ;
  logic [NUM_SRC-1:0]  pendingQ;
  logic [NUM_SRC-1:0]  maskQ;
  logic                unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:NUM_SRC];

  alarmRegCtrl u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .regRe   (regRe),
    .ctrl    (ctrlS)
  );

  alarmRegDatapath #(
    .NUM_LIVE   (NUM_LIVE),
    .NUM_STICKY (NUM_STICKY),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .liveIn   ({drvOpenIn, aisIn, losIn}),
    .stickyIn ({esUnfIn, esOvfIn}),
    .wrBits   (regWrData[NUM_SRC-1:0]),
    .ctrl     (ctrlS),
    .statusQ  (statusQ),
    .pendingQ (pendingQ),
    .maskQ    (maskQ),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/alarmRegChecker.sv
module alarmRegChecker
  import alarmRegPkg::*;
#(
  parameter int NUM_LIVE = 3,
  parameter int NUM_SRC  = 5,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_LIVE-1:0] liveIn,
  input logic                esOvfIn,
  input logic                esUnfIn,
  input logic [DATA_W-1:0]   regWrData,
  input alarmCtrl_t          ctrl,
  input logic [NUM_LIVE-1:0] statusQ,
  input logic [NUM_SRC-1:0]  pendingQ,
  input logic [NUM_SRC-1:0]  maskQ,
  input logic                irqOut
);

  assert_status_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusQ == $past(liveIn)));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LIVE; gi++) begin : gEdge
      assert_change_sets_event_R2: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(statusQ[gi]) |-> pendingQ[gi]);
    end
  endgenerate

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    esOvfIn |=> pendingQ[NUM_LIVE]);

  assert_unf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    esUnfIn |=> pendingQ[NUM_LIVE+1]);

  assert_pending_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.rdEvent || ctrl.wrMask) |=> ((pendingQ & $past(pendingQ)) == $past(pendingQ)));

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrMask |=> ((maskQ & $past(regWrData[NUM_SRC-1:0])) == $past(regWrData[NUM_SRC-1:0])));

  assert_mask_never_falls_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((maskQ & $past(maskQ)) == $past(maskQ)));

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendingQ & ~maskQ)) |=> irqOut);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(|(pendingQ & ~maskQ)) |=> !irqOut);

endmodule

bind alarmRegBank alarmRegChecker u_alarmRegChecker (
  .clk       (clk),
  .rstN      (rstN),
  .liveIn    ({drvOpenIn, aisIn, losIn}),
  .esOvfIn   (esOvfIn),
  .esUnfIn   (esUnfIn),
  .regWrData (regWrData),
  .ctrl      (ctrlS),
  .statusQ   (statusQ),
  .pendingQ  (pendingQ),
  .maskQ     (maskQ),
  .irqOut    (irqOut)
);

// File: tb/test_alarmRegBank.sv
`timescale 1ns/1ps
module test_alarmRegBank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       losIn = 0, aisIn = 0, drvOpenIn = 0, esOvfIn = 0, esUnfIn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic       regWe = 0, regRe = 0;
  logic [7:0] regRdData;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  alarmRegBank i_alarmRegBank (
    .clk(clk), .rstN(rstN), .losIn(losIn), .aisIn(aisIn), .drvOpenIn(drvOpenIn),
    .esOvfIn(esOvfIn), .esUnfIn(esUnfIn), .regAddr(regAddr), .regWrData(regWrData),
    .regWe(regWe), .regRe(regRe), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit [2:0] mStat;
  bit [4:0] mPend, mMask, mEvt, mClr;
  bit [7:0] mRd;
  bit       mIrq, mIrqNext;
  string    mRdTag = "R8";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = 0; mPend = 0; mMask = 0; mRd = 0; mIrq = 0; mRdTag = "R8";
    end else begin
      mIrqNext = 0;
      for (int i = 0; i < 5; i++) if (mPend[i] && !mMask[i]) mIrqNext = 1;
      mEvt = 0;
      if (losIn != mStat[0]) mEvt[0] = 1;
      if (aisIn != mStat[1]) mEvt[1] = 1;
      if (drvOpenIn != mStat[2]) mEvt[2] = 1;
      if (esOvfIn) mEvt[3] = 1;
      if (esUnfIn) mEvt[4] = 1;
      mClr = 0;
      if (regRe && regAddr == 1) mClr = 5'b11111;
      if (regWe && regAddr == 2) mClr = mClr | regWrData[4:0];
      if (regRe) begin
        case (regAddr)
          2'd0: begin mRd = {5'b0, mStat}; mRdTag = "R1"; end
          2'd1: begin mRd = {3'b0, mPend}; mRdTag = "R4"; end
          2'd2: begin mRd = {3'b0, mMask}; mRdTag = "R6"; end
          default: begin mRd = 0; mRdTag = "R9"; end
        endcase
      end
      if (regWe && regAddr == 2) mMask = mMask | regWrData[4:0];
      for (int i = 0; i < 5; i++) begin
        if (mClr[i]) mPend[i] = 0;
        if (mEvt[i]) mPend[i] = 1;
      end
      mStat = {drvOpenIn, aisIn, losIn};
      mIrq  = mIrqNext;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checkVal(mRdTag, "model rdData", regRdData, mRd);
      checkVal("R7", "model irq", irqOut, mIrq);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(logic [1:0] a, logic [7:0] exp, string tag);
    regAddr = a; regRe = 1'b1;
    @(negedge clk);
    regRe = 1'b0;
    checkVal(tag, "read", regRdData, exp);
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R8", "irq in reset", irqOut, 0);
    checkVal("R8", "rdData in reset", regRdData, 0);
    rstN = 1'b1;
    tick(2);
    readReg(2, 8'h00, "R8");
    readReg(1, 8'h00, "R8");
    checkVal("R8", "irq after reset", irqOut, 0);

    // loss of signal rises
    losIn = 1;
    tick(1);
    checkVal("R7", "irq one cycle after event not yet", irqOut, 0);
    tick(1);
    checkVal("R7", "irq raised", irqOut, 1);
    readReg(0, 8'h01, "R1");
    readReg(1, 8'h01, "R2");
    readReg(1, 8'h00, "R4");
    tick(1);
    checkVal("R7", "irq dropped after clear", irqOut, 0);

    // falling edge also an event
    losIn = 0; aisIn = 1; drvOpenIn = 1;
    tick(2);
    readReg(0, 8'h06, "R1");
    readReg(1, 8'h07, "R2");

    // overflow pulse held sticky
    esOvfIn = 1; tick(1); esOvfIn = 0;
    tick(5);
    readReg(1, 8'h08, "R3");
    readReg(1, 8'h00, "R3");

    // underflow arriving at the same edge as a read survives
    esUnfIn = 1;
    readReg(1, 8'h00, "R4");
    esUnfIn = 0;
    readReg(1, 8'h10, "R4");

    // mask alarm indication
    aisIn = 0; tick(1);
    writeReg(2, 8'h02);
    tick(1);
    checkVal("R5", "irq after mask clear", irqOut, 0);
    readReg(1, 8'h00, "R5");
    readReg(2, 8'h02, "R6");
    aisIn = 1; tick(3);
    checkVal("R7", "masked source no irq", irqOut, 0);
    readReg(1, 8'h02, "R2");

    // writing zero leaves mask
    writeReg(2, 8'h00);
    readReg(2, 8'h02, "R6");

    // same-edge mask write and event
    drvOpenIn = 0;
    writeReg(2, 8'h04);
    readReg(1, 8'h04, "R5");
    readReg(2, 8'h06, "R5");

    // writes elsewhere ignored, reserved reads zero
    esOvfIn = 1; tick(1); esOvfIn = 0;
    writeReg(1, 8'hFF);
    writeReg(0, 8'hFF);
    writeReg(3, 8'hFF);
    readReg(2, 8'h06, "R9");
    readReg(3, 8'h00, "R9");
    readReg(1, 8'h08, "R9");
    tick(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule